// File: doc/BRIEF.md
# Cache Line Refill Sequencer

This block stands in for the memory one level below a cache. It answers requests for whole 4-word lines of 32-bit words, 16 bytes per line. It walks each request through three kinds of phase: sending the address, accessing the storage array, and moving data over the bus. It counts the bus cycles spent in each phase and hands the words back in order. A small word-addressed store holds the data. Single-word stores load it while the block is idle.

The `ORG` parameter picks one of three organizations:

- **Narrow (`ORG`=0):** one word is accessed and then transferred, four times over.
- **Wide (`ORG`=1):** the whole line is read in a single access and sent in one beat.
- **Banked (`ORG`=2):** the four banks are accessed together, and their words then leave one per cycle.

In every organization the address phase takes one cycle, an array access takes fifteen cycles and a bus transfer takes one. After each request the block latches the request's total length, so the cost of each organization can be read directly.

Top module: `line_refill_seq`

## Requirements
- R1: While reset is asserted, `busy`, `rd_valid` and `rd_last` are low and `cyc_count` is zero.
- R2: With `ORG`=0, a request keeps `busy` high for 65 cycles. Counting the first busy cycle as cycle 1, word i of the line is delivered in cycle 17+16·i.
- R3: With `ORG`=1, a request keeps `busy` high for 17 cycles. The single beat comes in cycle 17 and carries word i in bits [32·i+31 : 32·i].
- R4: With `ORG`=2, a request keeps `busy` high for 20 cycles. Words 0 to 3 are delivered in cycles 17, 18, 19 and 20, and word i is held in bank i.
- R5: `rd_valid` is high only in transfer cycles, and `rd_last` is high exactly in the cycle that carries the final word of the line.
- R6: A request (`req_valid` high at a clock edge while `busy` is low) raises `busy` in the next cycle, and `busy` falls right after the last transfer. A `req_valid` seen while `busy` is high is ignored.
- R7: `cyc_count` changes only at the end of a request. It then holds that request's total length (65, 17 or 20) until the next request ends.
- R8: A store (`wr_en` high at an edge while `busy` is low) writes `wr_data` to word address `wr_addr`. The line holding word address a is a/4, and the word's position in that line is a mod 4. A store while `busy` is high is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Line read request |
| req_line | input | 4 | Line number to read |
| wr_en | input | 1 | Single-word store strobe |
| wr_addr | input | 6 | Word address of the store |
| wr_data | input | 32 | Store data |
| busy | output | 1 | High from the cycle after acceptance through the last transfer |
| rd_valid | output | 1 | Data beat present on `rd_data` |
| rd_last | output | 1 | Beat carries the final word of the line |
| rd_data | output | 32 × (4 if `ORG`=1, else 1) | Delivered word, or the whole line in wide mode |
| cyc_count | output | 8 | Total bus cycles of the most recent completed request |

## Verification
The assertions check these properties on every cycle:

- the relation between `busy`, `rd_valid` and `rd_last`;
- that no transfer happens before the address and access phases have elapsed;
- that `busy` rises after acceptance and falls after the final beat;
- that `cyc_count` moves only at the end of a request and then equals the organization's total.

The exact cycle of each beat, the word order, the lane layout of the wide beat, and whether ignored requests and stores really leave no trace can only be shown by the bench's scenarios. In those scenarios, all three organizations run side by side under the same stimulus and are compared against a per-organization model.

// File: rtl/line_refill_seq.sv
module line_refill_seq #(
  parameter int ORG      = 0,
  parameter int WORD_W   = 32,
  parameter int WORDS    = 4,
  parameter int DEPTH    = 64,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 15,
  parameter int CNT_W    = 8,
  localparam int OFF_W   = $clog2(WORDS),
  localparam int ADDR_W  = $clog2(DEPTH),
  localparam int LINE_W  = ADDR_W - OFF_W,
  localparam int XW      = (ORG == 1) ? WORDS : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 req_valid,
  input  logic [LINE_W-1:0]    req_line,
  input  logic                 wr_en,
  input  logic [ADDR_W-1:0]    wr_addr,
  input  logic [WORD_W-1:0]    wr_data,
  output logic                 busy,
  output logic                 rd_valid,
  output logic                 rd_last,
  output logic [WORD_W*XW-1:0] rd_data,
  output logic [CNT_W-1:0]     cyc_count
);
  localparam int ROWS   = DEPTH / WORDS;
  localparam int BEATS  = WORDS / XW;
  localparam int PH_MAX = (ADDR_CYC > ACC_CYC) ? ADDR_CYC : ACC_CYC;
  localparam int PH_W   = $clog2(PH_MAX + 1);
  localparam int BW     = (BEATS > 1) ? $clog2(BEATS) : 1;

  typedef enum logic [1:0] {IDLE, ADDR, ACC, XFER} phase_t;

  phase_t            phase;
  logic [PH_W-1:0]   ph_cnt;
  logic [BW-1:0]     beat;
  logic [LINE_W-1:0] line_q;
  logic [CNT_W-1:0]  run_cnt;
  logic [WORD_W-1:0] bank_rd [WORDS];

  wire ph_done    = (ph_cnt == '0);
  wire final_beat = (phase == XFER) && (beat == BW'(BEATS - 1));

  assign busy     = (phase != IDLE);
  assign rd_valid = (phase == XFER);
  assign rd_last  = final_beat;

  for (genvar b = 0; b < WORDS; b++) begin : g_bank
    logic [WORD_W-1:0] mem [ROWS];
    always_ff @(posedge clk)
      if (wr_en && !busy && wr_addr[OFF_W-1:0] == OFF_W'(b))
        mem[wr_addr[ADDR_W-1:OFF_W]] <= wr_data;
    assign bank_rd[b] = mem[line_q];
  end

  if (XW == WORDS) begin : g_wide
    for (genvar w = 0; w < WORDS; w++) begin : g_lane
      assign rd_data[w*WORD_W +: WORD_W] = bank_rd[w];
    end
  end else begin : g_serial
    assign rd_data = bank_rd[beat];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase     <= IDLE;
      ph_cnt    <= '0;
      beat      <= '0;
      line_q    <= '0;
      run_cnt   <= '0;
      cyc_count <= '0;
    end else begin
      if (busy) run_cnt <= run_cnt + 1'b1;
      unique case (phase)
        IDLE: if (req_valid) begin
          phase   <= ADDR;
          ph_cnt  <= PH_W'(ADDR_CYC - 1);
          beat    <= '0;
          line_q  <= req_line;
          run_cnt <= CNT_W'(1);
        end
        ADDR: if (ph_done) begin
          phase  <= ACC;
          ph_cnt <= PH_W'(ACC_CYC - 1);
        end else ph_cnt <= ph_cnt - 1'b1;
        ACC: if (ph_done) phase <= XFER;
             else ph_cnt <= ph_cnt - 1'b1;
        XFER: if (final_beat) begin
          phase     <= IDLE;
          cyc_count <= run_cnt;
        end else begin
          beat <= beat + 1'b1;
          if (ORG == 0) begin
            phase  <= ACC;
            ph_cnt <= PH_W'(ACC_CYC - 1);
          end
        end
        default: phase <= IDLE;
      endcase
    end
  end
endmodule

// File: rtl/line_refill_seq_chk.sv
module line_refill_seq_chk #(
  parameter int ORG      = 0,
  parameter int WORDS    = 4,
  parameter int ADDR_CYC = 1,
  parameter int ACC_CYC  = 15,
  parameter int CNT_W    = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             req_valid,
  input logic             busy,
  input logic             rd_valid,
  input logic             rd_last,
  input logic [CNT_W-1:0] cyc_count
);
  localparam int TOTAL = (ORG == 0) ? ADDR_CYC + WORDS * (ACC_CYC + 1) :
                         (ORG == 1) ? ADDR_CYC + ACC_CYC + 1 :
                                      ADDR_CYC + ACC_CYC + WORDS;

  logic [15:0] held;
  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) held <= '0;
    else if (busy) held <= held + 1'b1;
    else held <= '0;

  assert_last_with_beat_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |-> rd_valid);
  assert_beat_inside_busy_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> busy);
  assert_first_beat_late_R5: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> held >= 16'(ADDR_CYC + ACC_CYC));
  assert_accept_raises_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_valid) |=> busy);
  assert_last_drops_busy_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_last |=> !busy);
  assert_total_length_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> cyc_count == CNT_W'(TOTAL));
  assert_count_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_last |=> $stable(cyc_count));
endmodule

bind line_refill_seq line_refill_seq_chk #(
  .ORG(ORG), .WORDS(WORDS), .ADDR_CYC(ADDR_CYC), .ACC_CYC(ACC_CYC), .CNT_W(CNT_W)
) chk_i (
  .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .busy(busy),
  .rd_valid(rd_valid), .rd_last(rd_last), .cyc_count(cyc_count)
);

// File: tb/line_refill_seq_tb_top.sv
`timescale 1ns/1ps
module line_refill_seq_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, req_valid = 1'b0, wr_en = 1'b0;
  logic [3:0]  req_line = '0;
  logic [5:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  always #2 clk = ~clk;

  logic [2:0]   busy_o, vld_o, last_o;
  logic [7:0]   cyc_o  [3];
  logic [127:0] data_o [3];

  for (genvar g = 0; g < 3; g++) begin : g_org
    localparam int XWG = (g == 1) ? 4 : 1;
    logic [32*XWG-1:0] d;
    logic [7:0] c;
    line_refill_seq #(.ORG(g)) dut_i (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_line(req_line),
      .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .busy(busy_o[g]), .rd_valid(vld_o[g]), .rd_last(last_o[g]),
      .rd_data(d), .cyc_count(c));
    assign data_o[g] = 128'(d);
    assign cyc_o[g]  = c;
  end

  int vectors = 0, fails = 0, cycles = 0;
  logic run_chk = 1'b0;
  int k[3], ln[3], cyc_exp[3];
  logic [31:0] rmem [3][64];

  function automatic int tot(int g);
    return (g == 0) ? 65 : (g == 1) ? 17 : 20;
  endfunction

  function automatic int beat_of(int g, int kk);
    if (g == 0) return (kk >= 17 && kk <= 65 && (kk - 17) % 16 == 0) ? (kk - 17) / 16 : -1;
    if (g == 1) return (kk == 17) ? 0 : -1;
    return (kk >= 17 && kk <= 20) ? kk - 17 : -1;
  endfunction

  task automatic fail(string tag, int g, logic [127:0] act, logic [127:0] exp);
    fails++;
    $display("FAIL %s org%0d t=%0t: got %0h expected %0h", tag, g, $time, act, exp);
  endtask

  initial for (int g = 0; g < 3; g++) begin k[g] = 0; ln[g] = 0; cyc_exp[g] = 0; end

  always @(posedge clk) begin
    cycles++;
    for (int g = 0; g < 3; g++) begin
      if (!rst_n) begin
        k[g] = 0; cyc_exp[g] = 0;
      end else begin
        if (wr_en && k[g] == 0) rmem[g][wr_addr] = wr_data;
        if (k[g] == 0) begin
          if (req_valid) begin k[g] = 1; ln[g] = int'(req_line); end
        end else if (k[g] == tot(g)) begin
          cyc_exp[g] = tot(g); k[g] = 0;
        end else k[g] = k[g] + 1;
      end
    end
  end

  always @(negedge clk) if (run_chk) begin
    for (int g = 0; g < 3; g++) begin
      automatic int b = beat_of(g, k[g]);
      automatic string tg = (g == 0) ? "R2" : (g == 1) ? "R3" : "R4";
      automatic logic [127:0] ed = '0;
      vectors++;
      if (busy_o[g] !== (k[g] != 0)) fail("R6 busy", g, 128'(busy_o[g]), 128'(k[g] != 0));
      if (vld_o[g] !== (b >= 0)) fail({tg, " beat timing"}, g, 128'(vld_o[g]), 128'(b >= 0));
      if (last_o[g] !== (k[g] != 0 && k[g] == tot(g)))
        fail("R5 last", g, 128'(last_o[g]), 128'(k[g] == tot(g)));
      if (cyc_o[g] !== 8'(cyc_exp[g])) fail("R7 count", g, 128'(cyc_o[g]), 128'(cyc_exp[g]));
      if (b >= 0) begin
        if (g == 1) ed = {rmem[1][ln[1]*4+3], rmem[1][ln[1]*4+2], rmem[1][ln[1]*4+1], rmem[1][ln[1]*4]};
        else ed = 128'(rmem[g][ln[g]*4+b]);
        if (data_o[g] !== ed) fail({"R8 ", tg, " data"}, g, data_o[g], ed);
      end
    end
  end

  always @(posedge clk) if (cycles > 20000) begin
    fails++;
    $display("FAIL R6 watchdog: got no completion expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  task automatic request(int line);
    @(negedge clk); req_valid = 1'b1; req_line = 4'(line);
    @(negedge clk); req_valid = 1'b0;
  endtask

  task automatic store(int a, logic [31:0] v);
    @(negedge clk); wr_en = 1'b1; wr_addr = 6'(a); wr_data = v;
    @(negedge clk); wr_en = 1'b0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    for (int g = 0; g < 3; g++) begin
      vectors++;
      if ({busy_o[g], vld_o[g], last_o[g]} !== 3'b000 || cyc_o[g] !== 8'd0)
        fail("R1 reset", g, {busy_o[g], vld_o[g], last_o[g], cyc_o[g]}, 128'd0);
    end
    rst_n = 1'b1; run_chk = 1'b1;
    for (int a = 0; a < 64; a++) begin
      @(negedge clk); wr_en = 1'b1; wr_addr = 6'(a);
      wr_data = 32'hC0DE_0000 ^ (32'(a) * 32'h0103_0507);
    end
    @(negedge clk); wr_en = 1'b0;
    // R2 R3 R4: single request, then ignored request and store while busy (R6, R8)
    request(3);
    repeat (5) @(negedge clk);
    req_valid = 1'b1; req_line = 4'd9; wr_en = 1'b1; wr_addr = 6'd14; wr_data = 32'hBAD0_0001;
    @(negedge clk); req_valid = 1'b0; wr_en = 1'b0;
    repeat (75) @(negedge clk);
    request(3);
    repeat (70) @(negedge clk);
    // R6: request held high, back-to-back acceptance, boundary lines
    @(negedge clk); req_valid = 1'b1; req_line = 4'd15;
    repeat (140) @(negedge clk);
    req_line = 4'd0;
    repeat (140) @(negedge clk);
    req_valid = 1'b0;
    repeat (70) @(negedge clk);
    // R8: idle stores then readback
    store(28, 32'h1234_5678);
    store(31, 32'hFFFF_0000);
    store(63, 32'h8000_0001);
    request(7);
    repeat (70) @(negedge clk);
    request(15);
    repeat (70) @(negedge clk);
    run_chk = 1'b0;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule